// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block sits beside the execute stage of a small 32-bit processor core. In each cycle it looks at the pending exception sources: data abort, fast interrupt, normal interrupt, prefetch abort, software interrupt and undefined instruction. It picks one winner by a fixed priority and performs the hardware entry step for it. That step chooses the target mode, saves the status word, computes a link value from the current PC, sets the interrupt mask bits and produces the vector address to branch to. The block's own synchronous reset acts as the highest-priority exception. While reset is high it forces the reset entry state.

The block holds a compact model of the current program status word. The low byte of that word is laid out as follows: bits [4:0] hold the mode, bit 5 is the compressed-instruction-state flag, bit 6 is the fast-interrupt mask F and bit 7 is the normal-interrupt mask I. Software writes the word through a write port. A write takes effect only when the writing instruction completes in execute. An entry is registered: the new status, the saved status, the link value and the vector all appear one cycle after the request is sampled, together with a one-cycle taken pulse.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rst` is high, the status becomes 0x0000_00D3 (mode 10011, I=1, F=1, T=0), `taken_o` is 0, `vector_o` equals `VEC_BASE`, and `link_o` and `spsr_o` are 0.
- R2: When several requests are sampled in the same cycle, the winner is chosen in this order: data abort, then fast interrupt, then normal interrupt, then prefetch abort, then the shared lowest level. At the lowest level, undefined instruction wins over software interrupt if both are raised.
- R3: The two interrupts are handled as follows:
  - A normal interrupt is accepted only while status bit 7 is 0. A fast interrupt is accepted only while status bit 6 is 0.
  - Either interrupt is accepted only in a cycle where `instr_done_i` is 1.
  - The mask test uses the status held before any write that completes in the same cycle.
- R4: The entered mode codes are: data abort and prefetch abort 10111, fast interrupt 10001, normal interrupt 10010, software interrupt 10011, undefined instruction 11011.
- R5: Entry sets the mask bits as follows:
  - Fast-interrupt entry sets both bit 7 and bit 6.
  - Every other entry sets bit 7 and leaves bit 6 unchanged.
- R6: Every entry clears status bit 5 and carries status bits [31:8] through unchanged.
- R7: `spsr_o` receives the status word in force at entry. If a write completes in the same cycle, that is the written value.
- R8: `link_o` is set from the current PC as follows:
  - PC+8 for fast interrupt, normal interrupt and data abort.
  - PC+4 for prefetch abort, software interrupt and undefined instruction.
- R9: `vector_o` is `VEC_BASE` plus an offset: 0x04 undefined, 0x08 software interrupt, 0x0C prefetch abort, 0x10 data abort, 0x18 normal interrupt, 0x1C fast interrupt.
- R10: The outputs of an entry appear one cycle after the request is sampled, with `taken_o` high for that cycle. In a cycle with no accepted request, `taken_o` is 0 and the vector, link and saved status hold their values.
- R11: A status write on `sr_wr_en_i` takes effect only in a cycle where `instr_done_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the highest-priority exception |
| dabt_i | input | 1 | Data abort request |
| fiq_i | input | 1 | Fast interrupt line |
| irq_i | input | 1 | Normal interrupt line |
| pabt_i | input | 1 | Prefetch abort flag from execute |
| swi_i | input | 1 | Software interrupt flag from execute |
| und_i | input | 1 | Undefined instruction flag from execute |
| instr_done_i | input | 1 | Instruction in execute completes this cycle |
| pc_i | input | ADDR_W | Address of the instruction in execute |
| sr_wr_en_i | input | 1 | Status write request |
| sr_wr_data_i | input | 32 | Status write value |
| status_o | output | 32 | Current status word |
| mode_o | output | 5 | Current mode code |
| spsr_o | output | 32 | Status saved at the last entry |
| link_o | output | ADDR_W | Link value of the last entry |
| vector_o | output | ADDR_W | Vector address of the last entry |
| taken_o | output | 1 | One-cycle pulse marking an entry |

## Verification
Each exception source is first raised alone from an unmasked user-mode status. These runs separate the six mode, mask, link and vector combinations. Every pair that competes for priority is then driven together, including all six at once and the software/undefined tie, so that a wrong ordering shows up as a wrong vector. Further patterns test the acceptance conditions one by one: interrupts under each mask bit, an interrupt without instruction completion (a prefetch abort then wins), and a prefetch abort with F already set, which shows whether F is kept. Directed cases add a status write without completion and a completing write in the same cycle as an interrupt. The second case tells the pre-write mask test apart from the post-write saved status.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int SR_W  = 32;
  localparam int MODE_W = 5;
  localparam int BIT_I = 7;
  localparam int BIT_F = 6;
  localparam int BIT_T = 5;

  localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
  localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

  localparam logic [7:0] OFF_RST  = 8'h00;
  localparam logic [7:0] OFF_UND  = 8'h04;
  localparam logic [7:0] OFF_SWI  = 8'h08;
  localparam logic [7:0] OFF_PABT = 8'h0C;
  localparam logic [7:0] OFF_DABT = 8'h10;
  localparam logic [7:0] OFF_IRQ  = 8'h18;
  localparam logic [7:0] OFF_FIQ  = 8'h1C;

  localparam logic [SR_W-1:0] SR_RESET = 32'h0000_00D3;

  typedef enum logic [2:0] {
    EXC_NONE, EXC_DABT, EXC_FIQ, EXC_IRQ, EXC_PABT, EXC_SWI, EXC_UND
  } exc_kind_e;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
(
  input  logic      dabt_i,
  input  logic      fiq_i,
  input  logic      irq_i,
  input  logic      pabt_i,
  input  logic      swi_i,
  input  logic      und_i,
  input  logic      instr_done_i,
  input  logic      mask_i_i,
  input  logic      mask_f_i,
  output exc_kind_e kind_o
);
  logic fiq_ok, irq_ok;

  // interrupts wait for the instruction in execute and their mask bit
  assign fiq_ok = fiq_i && instr_done_i && !mask_f_i;
  assign irq_ok = irq_i && instr_done_i && !mask_i_i;

  always_comb begin
    if (dabt_i)      kind_o = EXC_DABT;
    else if (fiq_ok) kind_o = EXC_FIQ;
    else if (irq_ok) kind_o = EXC_IRQ;
    else if (pabt_i) kind_o = EXC_PABT;
    else if (und_i)  kind_o = EXC_UND;
    else if (swi_i)  kind_o = EXC_SWI;
    else             kind_o = EXC_NONE;
  end
endmodule

// File: rtl/exc_entry_calc.sv
module exc_entry_calc
  import exc_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
  input  exc_kind_e         kind_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [SR_W-1:0]   sr_i,
  output logic [SR_W-1:0]   sr_new_o,
  output logic [ADDR_W-1:0] link_o,
  output logic [ADDR_W-1:0] vector_o
);
  localparam logic [ADDR_W-1:0] ADJ4 = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] ADJ8 = ADDR_W'(8);

  logic [MODE_W-1:0] mode;
  logic              set_f;
  logic [7:0]        off;
  logic [ADDR_W-1:0] adj;

  always_comb begin
    mode  = sr_i[MODE_W-1:0];
    set_f = 1'b0;
    off   = OFF_RST;
    adj   = ADJ4;
    case (kind_i)
      EXC_DABT: begin mode = MODE_ABT; off = OFF_DABT; adj = ADJ8; end
      EXC_FIQ:  begin mode = MODE_FIQ; off = OFF_FIQ;  adj = ADJ8; set_f = 1'b1; end
      EXC_IRQ:  begin mode = MODE_IRQ; off = OFF_IRQ;  adj = ADJ8; end
      EXC_PABT: begin mode = MODE_ABT; off = OFF_PABT; end
      EXC_SWI:  begin mode = MODE_SVC; off = OFF_SWI;  end
      EXC_UND:  begin mode = MODE_UND; off = OFF_UND;  end
      default:  ;
    endcase
  end

  always_comb begin
    sr_new_o                = sr_i;
    sr_new_o[MODE_W-1:0]    = mode;
    sr_new_o[BIT_T]         = 1'b0;
    sr_new_o[BIT_I]         = 1'b1;
    sr_new_o[BIT_F]         = sr_i[BIT_F] | set_f;
  end

  assign link_o   = pc_i + adj;
  assign vector_o = VEC_BASE + ADDR_W'(off);
endmodule

// File: rtl/exc_status_model.sv
module exc_status_model
  import exc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en_i,
  input  logic            instr_done_i,
  input  logic [SR_W-1:0] wr_data_i,
  input  logic            take_i,
  input  logic [SR_W-1:0] sr_new_i,
  output logic [SR_W-1:0] sr_o,
  output logic [SR_W-1:0] sr_eff_o
);
  // a write lands only when its instruction completes
  assign sr_eff_o = (wr_en_i && instr_done_i) ? wr_data_i : sr_o;

  always_ff @(posedge clk) begin
    if (rst)         sr_o <= SR_RESET;
    else if (take_i) sr_o <= sr_new_i;
    else             sr_o <= sr_eff_o;
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dabt_i,
  input  logic              fiq_i,
  input  logic              irq_i,
  input  logic              pabt_i,
  input  logic              swi_i,
  input  logic              und_i,
  input  logic              instr_done_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              sr_wr_en_i,
  input  logic [31:0]       sr_wr_data_i,
  output logic [31:0]       status_o,
  output logic [4:0]        mode_o,
  output logic [31:0]       spsr_o,
  output logic [ADDR_W-1:0] link_o,
  output logic [ADDR_W-1:0] vector_o,
  output logic              taken_o
);
  exc_kind_e         kind;
  logic              take;
  logic [SR_W-1:0]   sr_cur, sr_eff, sr_new;
  logic [ADDR_W-1:0] link_n, vec_n;

  exc_arbiter u_arb (
    .dabt_i(dabt_i), .fiq_i(fiq_i), .irq_i(irq_i), .pabt_i(pabt_i),
    .swi_i(swi_i), .und_i(und_i), .instr_done_i(instr_done_i),
    .mask_i_i(sr_cur[BIT_I]), .mask_f_i(sr_cur[BIT_F]), .kind_o(kind)
  );

  exc_entry_calc #(.ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)) u_calc (
    .kind_i(kind), .pc_i(pc_i), .sr_i(sr_eff),
    .sr_new_o(sr_new), .link_o(link_n), .vector_o(vec_n)
  );

  assign take = (kind != EXC_NONE);

  exc_status_model u_sr (
    .clk(clk), .rst(rst), .wr_en_i(sr_wr_en_i), .instr_done_i(instr_done_i),
    .wr_data_i(sr_wr_data_i), .take_i(take), .sr_new_i(sr_new),
    .sr_o(sr_cur), .sr_eff_o(sr_eff)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      taken_o  <= 1'b0;
      spsr_o   <= '0;
      link_o   <= '0;
      vector_o <= VEC_BASE + ADDR_W'(OFF_RST);
    end else begin
      taken_o <= take;
      if (take) begin
        spsr_o   <= sr_eff;
        link_o   <= link_n;
        vector_o <= vec_n;
      end
    end
  end

  assign status_o = sr_cur;
  assign mode_o   = sr_cur[MODE_W-1:0];
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              dabt_i,
  input logic              fiq_i,
  input logic              irq_i,
  input logic              pabt_i,
  input logic              swi_i,
  input logic              und_i,
  input logic              instr_done_i,
  input logic [ADDR_W-1:0] pc_i,
  input logic              sr_wr_en_i,
  input logic [31:0]       status_o,
  input logic [31:0]       spsr_o,
  input logic [ADDR_W-1:0] link_o,
  input logic [ADDR_W-1:0] vector_o,
  input logic              taken_o
);
  logic any_req;
  assign any_req = dabt_i | fiq_i | irq_i | pabt_i | swi_i | und_i;

  assert_dabt_first_R2: assert property (@(posedge clk) disable iff (rst)
    dabt_i |=> (taken_o && status_o[4:0] == MODE_ABT &&
                vector_o == VEC_BASE + ADDR_W'(OFF_DABT)));

  assert_irq_masked_R3: assert property (@(posedge clk) disable iff (rst)
    (irq_i && status_o[BIT_I] && !fiq_i && !dabt_i && !pabt_i && !swi_i && !und_i)
      |=> !taken_o);

  assert_fiq_masks_R5: assert property (@(posedge clk) disable iff (rst)
    (taken_o && status_o[4:0] == MODE_FIQ) |-> (status_o[BIT_I] && status_o[BIT_F]));

  assert_tbit_clear_R6: assert property (@(posedge clk) disable iff (rst)
    taken_o |-> !status_o[BIT_T]);

  assert_saved_sr_R7: assert property (@(posedge clk) disable iff (rst)
    (taken_o && !$past(sr_wr_en_i && instr_done_i)) |-> spsr_o == $past(status_o));

  assert_dabt_link_R8: assert property (@(posedge clk) disable iff (rst)
    dabt_i |=> link_o == $past(pc_i) + ADDR_W'(8));

  assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !any_req |=> (!taken_o && $stable(vector_o) && $stable(link_o)));

  assert_wr_needs_done_R11: assert property (@(posedge clk) disable iff (rst)
    (sr_wr_en_i && !instr_done_i && !any_req) |=> $stable(status_o));
endmodule

bind exc_entry_ctrl exc_entry_chk #(.ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)) u_chk (
  .clk(clk), .rst(rst), .dabt_i(dabt_i), .fiq_i(fiq_i), .irq_i(irq_i),
  .pabt_i(pabt_i), .swi_i(swi_i), .und_i(und_i), .instr_done_i(instr_done_i),
  .pc_i(pc_i), .sr_wr_en_i(sr_wr_en_i), .status_o(status_o), .spsr_o(spsr_o),
  .link_o(link_o), .vector_o(vector_o), .taken_o(taken_o)
);

// File: tb/test_exc_entry_ctrl.sv
module test_exc_entry_ctrl;
  localparam int          CLK_PERIOD = 10;
  localparam int          AW         = 32;
  localparam logic [31:0] BASE       = 32'hFFFF_0000;
  localparam int          NV         = 17;

  // {req[5:0]=dabt,fiq,irq,pabt,swi,und, done, sr[7:0], pc[15:0],
  //  exp_taken, exp_sr[7:0], exp_vec_off[7:0], exp_link[15:0]}
  localparam logic [63:0] VECS [NV] = '{
    {6'b100000, 1'b1, 8'h10, 16'h0100, 1'b1, 8'h97, 8'h10, 16'h0108}, // R4 data abort
    {6'b010000, 1'b1, 8'h10, 16'h0200, 1'b1, 8'hD1, 8'h1C, 16'h0208}, // R5 fast sets I,F
    {6'b001000, 1'b1, 8'h10, 16'h0204, 1'b1, 8'h92, 8'h18, 16'h020C}, // normal irq
    {6'b000100, 1'b0, 8'h10, 16'h0300, 1'b1, 8'h97, 8'h0C, 16'h0304}, // prefetch abort
    {6'b000100, 1'b0, 8'h50, 16'h0310, 1'b1, 8'hD7, 8'h0C, 16'h0314}, // R5 F kept
    {6'b000010, 1'b0, 8'h10, 16'h0400, 1'b1, 8'h93, 8'h08, 16'h0404}, // swi
    {6'b000001, 1'b0, 8'h30, 16'h0410, 1'b1, 8'h9B, 8'h04, 16'h0414}, // R6 T cleared
    {6'b111111, 1'b1, 8'h10, 16'h0500, 1'b1, 8'h97, 8'h10, 16'h0508}, // R2 all: dabt
    {6'b011000, 1'b1, 8'h10, 16'h0600, 1'b1, 8'hD1, 8'h1C, 16'h0608}, // R2 fiq>irq
    {6'b001100, 1'b1, 8'h10, 16'h0700, 1'b1, 8'h92, 8'h18, 16'h0708}, // R2 irq>pabt
    {6'b001100, 1'b0, 8'h10, 16'h0710, 1'b1, 8'h97, 8'h0C, 16'h0714}, // R3 irq waits
    {6'b001010, 1'b1, 8'h90, 16'h0800, 1'b1, 8'h93, 8'h08, 16'h0804}, // R3 I masked
    {6'b011000, 1'b1, 8'h50, 16'h0900, 1'b1, 8'hD2, 8'h18, 16'h0908}, // R3 F masked
    {6'b001000, 1'b1, 8'h90, 16'h0A00, 1'b0, 8'h90, 8'h00, 16'h0000}, // R3 no entry
    {6'b000011, 1'b0, 8'h10, 16'h0B00, 1'b1, 8'h9B, 8'h04, 16'h0B04}, // R2 und>swi
    {6'b001000, 1'b0, 8'h10, 16'h0C00, 1'b0, 8'h10, 8'h00, 16'h0000}, // R3 no done
    {6'b010000, 1'b1, 8'hD0, 16'h0D00, 1'b0, 8'hD0, 8'h00, 16'h0000}  // R3 both masked
  };

  logic clk = 0, rst = 1;
  logic dabt, fiq, irq, pabt, swi, und, done, wr_en;
  logic [AW-1:0] pc;
  logic [31:0]   wr_data;
  logic [31:0]   status, spsr;
  logic [4:0]    mode;
  logic [AW-1:0] link, vector;
  logic          taken;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_ctrl #(.ADDR_W(AW), .VEC_BASE(BASE)) i_exc_entry_ctrl (
    .clk(clk), .rst(rst), .dabt_i(dabt), .fiq_i(fiq), .irq_i(irq),
    .pabt_i(pabt), .swi_i(swi), .und_i(und), .instr_done_i(done), .pc_i(pc),
    .sr_wr_en_i(wr_en), .sr_wr_data_i(wr_data), .status_o(status),
    .mode_o(mode), .spsr_o(spsr), .link_o(link), .vector_o(vector),
    .taken_o(taken)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic set_req(input logic [5:0] r);
    {dabt, fiq, irq, pabt, swi, und} = r;
  endtask

  // called at a negedge; status holds s after the next posedge
  task automatic load_sr(input logic [31:0] s);
    set_req(6'b0); wr_en = 1; done = 1; wr_data = s;
    @(negedge clk);
    wr_en = 0; done = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    set_req(6'b0); done = 0; wr_en = 0; wr_data = 0; pc = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset status", status, 32'hD3);
    chk("R1 reset taken", taken, 0);
    chk("R1 reset vector", vector, BASE);
    chk("R1 reset link", link, 0);
    chk("R1 reset saved", spsr, 0);
    rst = 0;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      logic [63:0]   v;
      logic [AW-1:0] vprev, lprev;
      v = VECS[k];
      load_sr({24'h0, v[56:49]});
      vprev = vector; lprev = link;
      set_req(v[63:58]); done = v[57]; pc = {16'h0, v[48:33]};
      @(negedge clk);
      chk($sformatf("R10 taken #%0d", k), taken, v[32]);
      chk($sformatf("R2/R4/R5 status #%0d", k), status, {24'h0, v[31:24]});
      if (v[32]) begin
        chk($sformatf("R9 vector #%0d", k), vector, BASE + v[23:16]);
        chk($sformatf("R8 link #%0d", k), link, {16'h0, v[15:0]});
        chk($sformatf("R7 saved #%0d", k), spsr, {24'h0, v[56:49]});
      end else begin
        chk($sformatf("R10 vector hold #%0d", k), vector, vprev);
        chk($sformatf("R10 link hold #%0d", k), link, lprev);
      end
      set_req(6'b0); done = 0;
    end

    // R11: write without completion is dropped
    load_sr(32'h10);
    wr_en = 1; done = 0; wr_data = 32'h1F;
    @(negedge clk);
    chk("R11 write without done", status, 32'h10);
    wr_en = 0;

    // R7/R3: completing write and interrupt in the same cycle
    load_sr(32'h10);
    wr_en = 1; done = 1; wr_data = 32'h90; irq = 1; pc = 32'h0D00;
    @(negedge clk);
    chk("R3 old mask used", taken, 1);
    chk("R7 saved = written", spsr, 32'h90);
    chk("R4 irq mode", mode, 5'b10010);
    chk("R8 irq link", link, 32'h0D08);
    wr_en = 0; done = 0; irq = 0;
    @(negedge clk);
    chk("R10 pulse ends", taken, 0);
    chk("R10 status held", status, 32'h92);
    chk("R10 vector held", vector, BASE + 32'h18);

    // R1: reset in mid-run
    rst = 1;
    @(negedge clk);
    chk("R1 mid reset status", status, 32'hD3);
    chk("R1 mid reset vector", vector, BASE);
    rst = 0;
    @(negedge clk);
    chk("R1 after reset taken", taken, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule